// File: doc/BRIEF.md
# Four-Processor Device Interrupt Router

The router collects up to 64 level-sensitive device interrupt lines into one shared raw request register and fans them out to four processors. Each processor has its own enable mask. Each processor's interrupt output stays high as long as at least one of its enabled requests is pending. A cascaded legacy interrupt controller feeds one line of its own, and that line occupies a fixed high bit of the raw register.

Software reaches the router through a 64-bit register port with registered reads. Through this port it writes and reads back each processor's mask, reads the shared raw requests, and reads a per-processor view that shows only the enabled requests. Every access must use all eight byte lanes. An access to an offset outside the map, or one with partial lanes, is flagged as an access error. A faulting read returns all ones.

Top module: `cpu_irq_router`

## Requirements
- R1: Raw request bit i (other than the cascade bit) follows device line i one clock after it is sampled. The raw register reads at offset 0x300.
- R2: The interrupt output of processor n is registered. It becomes high one clock after a mask write or line change that makes (mask n AND raw) nonzero, and low one clock after that value becomes zero. An output whose present-parameter bit is 0 stays low.
- R3: The masks of processors 0, 1, 2 and 3 are written and read back at offsets 0x200, 0x240, 0x600 and 0x640 respectively. A write to one mask leaves the other three unchanged.
- R4: Offsets 0x280, 0x2C0, 0x680 and 0x6C0 return the mask of processors 0, 1, 2 and 3 ANDed with the raw requests. Writes to these four offsets and to 0x300 change no state and raise no error.
- R5: After reset, all masks and the raw register are zero, all interrupt outputs are low, and the error flag is low.
- R6: Raw request bit 55 is driven by the cascade input. Device line 55 is ignored.
- R7: A read or write to any offset not listed in R1, R3 or R4 raises the error flag one clock later. Such a read returns all ones, and such a write changes no state.
- R8: An access with any byte enable low raises the error flag. If it is a write it changes no mask, and if it is a read it returns all ones.
- R9: Read data and the error flag are valid on the clock after the one where the read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_irq | input | 64 | Level-sensitive device interrupt lines |
| cascade_irq | input | 1 | Output of the cascaded legacy controller |
| csr_rd | input | 1 | Read strobe, one cycle |
| csr_wr | input | 1 | Write strobe, one cycle |
| csr_addr | input | 12 | Byte offset of the register |
| csr_be | input | 8 | Byte enables; all ones required |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Registered read data |
| csr_err | output | 1 | Access error, one clock after the access |
| cpu_irq | output | 4 | Per-processor interrupt outputs |

## Verification
The design has one register stage for every result. A line change or mask write presented before a clock edge shows up on the interrupt outputs and in the raw register right after that edge. Read data and the error flag appear one edge after the read strobe. The bench drives every stimulus on a falling edge and samples results at the next falling edge, which is after exactly one rising edge. Register reads issued after a stimulus therefore observe state that is already settled. A walking one over all 64 lines, checked against four contrasting masks, compares every output and read view with values the bench computes itself.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam int unsigned IRQR_NCPU   = 4;
  localparam int unsigned IRQR_AW     = 12;
  localparam int unsigned IRQR_CPU_W  = $clog2(IRQR_NCPU);
  localparam logic [IRQR_AW-1:0] IRQR_RAW_OFF  = 12'h300;
  localparam logic [IRQR_AW-1:0] IRQR_VIEW_GAP = 12'h080;
  localparam logic [IRQR_AW-1:0] IRQR_STRIDE   = 12'h040;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_VIEW = 2'd2,
    SEL_RAW  = 2'd3
  } irqr_sel_e;

  typedef struct packed {
    irqr_sel_e             sel;
    logic [IRQR_CPU_W-1:0] cpu;
  } irqr_dec_t;

  // Mask offsets come in two pairs: processors 0/1 low, 2/3 high.
  function automatic logic [IRQR_AW-1:0] irqr_mask_off(input int unsigned n);
    logic [IRQR_AW-1:0] base;
    base = (n < 2) ? 12'h200 : 12'h600;
    return base + ((n % 2 == 1) ? IRQR_STRIDE : '0);
  endfunction

  function automatic logic [IRQR_AW-1:0] irqr_view_off(input int unsigned n);
    return irqr_mask_off(n) + IRQR_VIEW_GAP;
  endfunction

endpackage

// File: rtl/irqr_csr_decode.sv
module irqr_csr_decode
  import irqr_pkg::*;
(
  input  logic [IRQR_AW-1:0] addr,
  output irqr_dec_t          dec
);

  always_comb begin
    dec.sel = SEL_NONE;
    dec.cpu = '0;
    if (addr == IRQR_RAW_OFF) begin
      dec.sel = SEL_RAW;
    end
    for (int unsigned n = 0; n < IRQR_NCPU; n++) begin
      if (addr == irqr_mask_off(n)) begin
        dec.sel = SEL_MASK;
        dec.cpu = IRQR_CPU_W'(n);
      end
      if (addr == irqr_view_off(n)) begin
        dec.sel = SEL_VIEW;
        dec.cpu = IRQR_CPU_W'(n);
      end
    end
  end

endmodule

// File: rtl/irqr_raw_capture.sv
module irqr_raw_capture #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned CASC_BIT = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dev_irq,
  input  logic              cascade_irq,
  output logic [DATA_W-1:0] raw_nxt,
  output logic [DATA_W-1:0] raw_q
);

  localparam logic [DATA_W-1:0] CASC_MASK = DATA_W'(1) << CASC_BIT;

  generate
    if (CASC_BIT >= DATA_W) begin : g_bad_casc
      initial $error("cascade bit outside raw register");
    end
  endgenerate

  always_comb begin
    raw_nxt = (dev_irq & ~CASC_MASK) | ({DATA_W{cascade_irq}} & CASC_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_nxt;
  end

endmodule

// File: rtl/irqr_cpu_lane.sv
module irqr_cpu_lane #(
  parameter int unsigned DATA_W  = 64,
  parameter bit          PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_nxt,
  output logic [DATA_W-1:0] mask_q,
  output logic              irq_q
);

  logic [DATA_W-1:0] mask_nxt;

  always_comb begin
    mask_nxt = wr_en ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_nxt;
  end

  generate
    if (PRESENT) begin : g_live
      // Output sees the same next state the mask and raw registers load.
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(mask_nxt & raw_nxt);
      end
    end else begin : g_absent
      always_ff @(posedge clk) begin
        irq_q <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/cpu_irq_router.sv
module cpu_irq_router
  import irqr_pkg::*;
#(
  parameter int unsigned        DATA_W      = 64,
  parameter int unsigned        CASC_BIT    = 55,
  parameter logic [IRQR_NCPU-1:0] CPU_PRESENT = 4'b1111
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_W-1:0]    dev_irq,
  input  logic                 cascade_irq,
  input  logic                 csr_rd,
  input  logic                 csr_wr,
  input  logic [IRQR_AW-1:0]   csr_addr,
  input  logic [DATA_W/8-1:0]  csr_be,
  input  logic [DATA_W-1:0]    csr_wdata,
  output logic [DATA_W-1:0]    csr_rdata,
  output logic                 csr_err,
  output logic [IRQR_NCPU-1:0] cpu_irq
);

  localparam int unsigned BE_W = DATA_W / 8;

  irqr_dec_t                        dec;
  logic [DATA_W-1:0]                raw_nxt;
  logic [DATA_W-1:0]                raw_q;
  logic [IRQR_NCPU-1:0][DATA_W-1:0] mask_q;
  logic                             full_lanes;
  logic                             bad_access;
  logic [DATA_W-1:0]                rd_value;

  irqr_csr_decode i_decode (
    .addr (csr_addr),
    .dec  (dec)
  );

  irqr_raw_capture #(
    .DATA_W   (DATA_W),
    .CASC_BIT (CASC_BIT)
  ) i_raw (
    .clk         (clk),
    .rst         (rst),
    .dev_irq     (dev_irq),
    .cascade_irq (cascade_irq),
    .raw_nxt     (raw_nxt),
    .raw_q       (raw_q)
  );

  assign full_lanes = (csr_be == {BE_W{1'b1}});
  assign bad_access = (csr_rd | csr_wr) & (~full_lanes | (dec.sel == SEL_NONE));

  generate
    for (genvar n = 0; n < IRQR_NCPU; n++) begin : g_lane
      logic wr_hit;
      assign wr_hit = csr_wr & full_lanes & (dec.sel == SEL_MASK)
                    & (dec.cpu == IRQR_CPU_W'(n));
      irqr_cpu_lane #(
        .DATA_W  (DATA_W),
        .PRESENT (CPU_PRESENT[n])
      ) i_lane (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_hit),
        .wdata   (csr_wdata),
        .raw_nxt (raw_nxt),
        .mask_q  (mask_q[n]),
        .irq_q   (cpu_irq[n])
      );
    end
  endgenerate

  always_comb begin
    rd_value = '1;
    if (full_lanes) begin
      unique case (dec.sel)
        SEL_MASK: rd_value = mask_q[dec.cpu];
        SEL_VIEW: rd_value = mask_q[dec.cpu] & raw_q;
        SEL_RAW:  rd_value = raw_q;
        default:  rd_value = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
      csr_err   <= 1'b0;
    end else begin
      csr_err <= bad_access;
      if (csr_rd) csr_rdata <= rd_value;
    end
  end

endmodule

// File: rtl/cpu_irq_router_chk.sv
module cpu_irq_router_chk
  import irqr_pkg::*;
#(
  parameter int unsigned          DATA_W      = 64,
  parameter int unsigned          CASC_BIT    = 55,
  parameter logic [IRQR_NCPU-1:0] CPU_PRESENT = 4'b1111
) (
  input logic                             clk,
  input logic                             rst,
  input logic [DATA_W-1:0]                dev_irq,
  input logic                             cascade_irq,
  input logic                             csr_rd,
  input logic                             csr_wr,
  input logic [IRQR_AW-1:0]               csr_addr,
  input logic [DATA_W/8-1:0]              csr_be,
  input logic [DATA_W-1:0]                csr_wdata,
  input logic [DATA_W-1:0]                csr_rdata,
  input logic                             csr_err,
  input logic [IRQR_NCPU-1:0]             cpu_irq,
  input logic [DATA_W-1:0]                raw_q,
  input logic [IRQR_NCPU-1:0][DATA_W-1:0] mask_q
);

  localparam logic [DATA_W-1:0] CMASK = DATA_W'(1) << CASC_BIT;

  AST_RAW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & ~CMASK) == ($past(dev_irq) & ~CMASK))); // R1

  generate
    for (genvar n = 0; n < IRQR_NCPU; n++) begin : g_irq
      AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        cpu_irq[n] == (CPU_PRESENT[n] && (|(mask_q[n] & raw_q)))); // R2
    end
  endgenerate

  AST_MASK_TARGET: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && (&csr_be) && csr_addr == 12'h240)
      |=> (mask_q[1] == $past(csr_wdata)) && (mask_q[0] == $past(mask_q[0]))); // R3

  AST_VIEW_RO: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && (csr_addr == 12'h280 || csr_addr == 12'h2C0 || csr_addr == 12'h300))
      |=> $stable(mask_q)); // R4

  AST_CASCADE_BIT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (raw_q[CASC_BIT] == $past(cascade_irq))); // R6

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    csr_err |-> $past(csr_rd || csr_wr)); // R7

  AST_ERR_ONES: assert property (@(posedge clk) disable iff (rst)
    (csr_err && $past(csr_rd)) |-> (&csr_rdata)); // R7

  AST_PARTIAL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !(&csr_be)) |=> ($stable(mask_q) && csr_err)); // R8

endmodule

bind cpu_irq_router cpu_irq_router_chk #(
  .DATA_W      (DATA_W),
  .CASC_BIT    (CASC_BIT),
  .CPU_PRESENT (CPU_PRESENT)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .dev_irq     (dev_irq),
  .cascade_irq (cascade_irq),
  .csr_rd      (csr_rd),
  .csr_wr      (csr_wr),
  .csr_addr    (csr_addr),
  .csr_be      (csr_be),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .csr_err     (csr_err),
  .cpu_irq     (cpu_irq),
  .raw_q       (raw_q),
  .mask_q      (mask_q)
);

// File: tb/test_cpu_irq_router.sv
`timescale 1ns/1ps
module test_cpu_irq_router;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] dev_irq = '0;
  logic        cascade_irq = 1'b0;
  logic        csr_rd = 1'b0;
  logic        csr_wr = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [7:0]  csr_be = 8'hFF;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_err;
  logic [3:0]  cpu_irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic [63:0] m [4];
  logic [11:0] mask_off [4] = '{12'h200, 12'h240, 12'h600, 12'h640};
  logic [11:0] view_off [4] = '{12'h280, 12'h2C0, 12'h680, 12'h6C0};

  always #2.5 clk = ~clk;

  cpu_irq_router i_cpu_irq_router (
    .clk(clk), .rst(rst), .dev_irq(dev_irq), .cascade_irq(cascade_irq),
    .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_be(csr_be),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_err(csr_err),
    .cpu_irq(cpu_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [63:0] d,
                          input logic [7:0] be, output logic err);
    @(negedge clk);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d; csr_be = be;
    @(negedge clk);
    csr_wr = 1'b0; csr_be = 8'hFF;
    err = csr_err;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [7:0] be,
                         output logic [63:0] d, output logic err);
    @(negedge clk);
    csr_rd = 1'b1; csr_addr = a; csr_be = be;
    @(negedge clk);
    csr_rd = 1'b0; csr_be = 8'hFF;
    d = csr_rdata; err = csr_err;
  endtask

  task automatic set_lines(input logic [63:0] d, input logic c);
    @(negedge clk);
    dev_irq = d; cascade_irq = c;
    @(negedge clk);
  endtask

  function automatic logic [63:0] exp_raw(input logic [63:0] d, input logic c);
    logic [63:0] r;
    r = d;
    r[55] = c;
    return r;
  endfunction

  function automatic logic [3:0] exp_irq(input logic [63:0] r);
    logic [3:0] v;
    for (int n = 0; n < 4; n++) v[n] = |(m[n] & r);
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic        e;
    logic [63:0] r;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5: reset state
    chk("R5", "irq after reset", {60'd0, cpu_irq}, 64'd0);
    chk("R5", "err after reset", {63'd0, csr_err}, 64'd0);
    do_read(12'h300, 8'hFF, d, e);
    chk("R5", "raw after reset", d, 64'd0);
    for (int n = 0; n < 4; n++) begin
      do_read(mask_off[n], 8'hFF, d, e);
      chk("R5", "mask after reset", d, 64'd0);
    end

    // R3: program four contrasting masks, read each back
    m[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    m[1] = 64'h5555_5555_5555_5555;
    m[2] = 64'hAAAA_AAAA_AAAA_AAAA;
    m[3] = 64'hFFFF_FFFF_0000_0000;
    for (int n = 0; n < 4; n++) begin
      do_write(mask_off[n], m[n], 8'hFF, e);
      chk("R3", "mask write err", {63'd0, e}, 64'd0);
    end
    for (int n = 0; n < 4; n++) begin
      do_read(mask_off[n], 8'hFF, d, e);
      chk("R3", "mask readback", d, m[n]);
    end

    // R1 R2 R4 R6 R9: walking one over all device lines
    for (int b = 0; b < 64; b++) begin
      set_lines(64'd1 << b, 1'b0);
      r = exp_raw(64'd1 << b, 1'b0);
      chk("R2", "irq walking one", {60'd0, cpu_irq}, {60'd0, exp_irq(r)});
      do_read(12'h300, 8'hFF, d, e);
      chk((b == 55) ? "R6" : "R1", "raw walking one", d, r);
      for (int n = 0; n < 4; n++) begin
        do_read(view_off[n], 8'hFF, d, e);
        chk("R4", "masked view", d, m[n] & r);
      end
    end

    // R6: cascade input drives bit 55
    set_lines(64'd0, 1'b1);
    r = exp_raw(64'd0, 1'b1);
    chk("R6", "irq from cascade", {60'd0, cpu_irq}, {60'd0, exp_irq(r)});
    do_read(12'h300, 8'hFF, d, e);
    chk("R6", "raw with cascade", d, 64'h0080_0000_0000_0000);

    // R2: mask write drops an output one clock later
    set_lines(64'h0000_0000_0000_0002, 1'b0);
    chk("R2", "irq bit1 before", {60'd0, cpu_irq}, 64'h9 & 64'h1 | 64'h4);
    do_write(12'h600, 64'd0, 8'hFF, e);
    m[2] = 64'd0;
    chk("R2", "irq after mask clear", {60'd0, cpu_irq}, 64'h1);

    // R3: write to 0x240 touches CPU1 only
    do_write(12'h240, 64'h0000_0000_0000_0002, 8'hFF, e);
    m[1] = 64'h2;
    chk("R3", "irq after cpu1 mask", {60'd0, cpu_irq}, 64'h3);
    do_read(12'h200, 8'hFF, d, e);
    chk("R3", "cpu0 mask untouched", d, m[0]);
    do_read(12'h240, 8'hFF, d, e);
    chk("R3", "cpu1 mask updated", d, m[1]);

    // R4: writes to read-only offsets are ignored
    do_write(12'h2C0, 64'd0, 8'hFF, e);
    chk("R4", "view write err", {63'd0, e}, 64'd0);
    do_write(12'h300, 64'hFFFF, 8'hFF, e);
    do_read(12'h240, 8'hFF, d, e);
    chk("R4", "mask after view write", d, m[1]);
    do_read(12'h300, 8'hFF, d, e);
    chk("R4", "raw after raw write", d, 64'h2);

    // R7: unmapped offsets
    do_read(12'h000, 8'hFF, d, e);
    chk("R7", "unmapped read err", {63'd0, e}, 64'd1);
    chk("R7", "unmapped read data", d, '1);
    do_read(12'h208, 8'hFF, d, e);
    chk("R7", "misaligned read data", d, '1);
    do_write(12'h208, 64'd0, 8'hFF, e);
    chk("R7", "unmapped write err", {63'd0, e}, 64'd1);
    do_read(12'h200, 8'hFF, d, e);
    chk("R7", "mask after unmapped write", d, m[0]);
    chk("R9", "err clears on good read", {63'd0, e}, 64'd0);

    // R8: partial byte enables
    do_write(12'h200, 64'd0, 8'h0F, e);
    chk("R8", "partial write err", {63'd0, e}, 64'd1);
    chk("R8", "irq after partial write", {60'd0, cpu_irq}, 64'h3);
    do_read(12'h200, 8'hFE, d, e);
    chk("R8", "partial read err", {63'd0, e}, 64'd1);
    chk("R8", "partial read data", d, '1);
    do_read(12'h200, 8'hFF, d, e);
    chk("R8", "mask after partial write", d, m[0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule